// File: doc/BRIEF.md
# Variant-Aware Instruction Cycle Accountant

This block keeps a signed budget of clock cycles for a processor core that can be configured as one of three chip variants. Each time an instruction retires, the core presents a cost command. The command carries a kind code and up to three cost fields. Two of the fields are packed words that hold one cost per variant, each in its own byte lane. The block picks the cost that applies and subtracts it from the budget. The choice depends on the configured variant, on whether the operand is a register or a memory location (taken from the ModRM byte), and on whether the operand address is odd or even.

The variant select is itself the bit offset of that variant's lane, so the lane is reached by a plain right shift. A load strobe sets a new budget, for example at the start of a time slice. The exhausted flag tells the scheduler that the slice has been used up.

Top module: `cyc_budget_meter`

## Requirements
- R1: While reset is asserted the budget reads 0 and the exhausted flag reads 1.
- R2: When `load` is high at a clock edge, the budget takes `load_value` after that edge. A command issued in the same cycle is discarded.
- R3: A per-variant cost is read from a 24-bit packed word as `(word >> variant_sel) & 0x7F`. Code 0 selects bits 7:0, code 8 selects bits 15:8 and code 16 selects bits 23:16. Bit 7 of the lane is always dropped.
- R4: Any `variant_sel` value other than 0, 8 or 16 is handled exactly like code 0.
- R5: Kind 0 (flat) subtracts the full 8-bit `cost_flat` for every variant.
- R6: Kind 2 (address parity) charges the lane of `cost_a` when `addr_lsb` is 1 and the lane of `cost_b` when it is 0.
- R7: Kind 3 (operand form) charges the lane of `cost_a` when `modrm` is 0xC0 or above (register operand) and the lane of `cost_b` otherwise (memory operand).
- R8: Kind 4 (mixed) charges `cost_flat` for a register operand. For a memory operand it charges the lane of `cost_a` on an odd address and the lane of `cost_b` on an even one.
- R9: Kind 1 charges the lane of `cost_a`. Kinds 5, 6 and 7 leave the budget unchanged.
- R10: `exhausted` is high exactly when the budget is zero or negative.
- R11: Without `cmd_valid` or `load`, the budget holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| variant_sel | input | 5 | Variant code, which is the lane bit offset (0, 8 or 16) |
| cmd_valid | input | 1 | A cost command is present this cycle |
| cmd_kind | input | 3 | Selection rule for the command (0 to 4; 5 to 7 have no effect) |
| cost_a | input | 24 | Packed costs: odd-address, register-form or plain per-variant set |
| cost_b | input | 24 | Packed costs: even-address or memory-form set |
| cost_flat | input | 8 | Cost that applies to every variant |
| modrm | input | 8 | Operand-form byte |
| addr_lsb | input | 1 | Least significant bit of the operand address |
| load | input | 1 | Budget load strobe |
| load_value | input | 32 | New budget value |
| budget | output | 32 | Remaining signed cycle budget |
| exhausted | output | 1 | Budget is zero or below |

## Verification
The bench builds the block with its default parameters: three 8-bit lanes, a 7-bit lane mask and a 32-bit counter. With these values the mask boundary can be reached by lanes whose bit 7 is set. It can also reach the legal and illegal variant codes at 0, 8, 16 and beyond 23, and the register/memory boundary at 0xBF versus 0xC0. Loads push the budget across zero in both directions, so the exhausted flag is seen to switch at exactly zero and at minus one.

// File: rtl/cyc_budget_pkg.sv
package cyc_budget_pkg;

   typedef enum logic [2:0] {
      CK_FLAT    = 3'd0,
      CK_VARIANT = 3'd1,
      CK_PARITY  = 3'd2,
      CK_FORM    = 3'd3,
      CK_MIXED   = 3'd4
   } cost_kind_e;

   // ModRM values at or above this mark a register operand
   localparam logic [7:0] REG_FORM_MIN = 8'hC0;

endpackage

// File: rtl/cyc_lane_pick.sv
module cyc_lane_pick #(
   parameter int LANE_W  = 8,
   parameter int NUM_VAR = 3,
   parameter int MASK_W  = 7,
   localparam int WORD_W = LANE_W * NUM_VAR,
   localparam int CODE_W = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0] word,
   input  logic [CODE_W-1:0] code,
   output logic [MASK_W-1:0] cost
);

   logic [NUM_VAR-1:0] hit;
   logic [CODE_W-1:0]  eff_code;
   logic [WORD_W-1:0]  shifted;

   // One comparator per legal lane offset
   for (genvar k = 0; k < NUM_VAR; k++) begin : g_hit
      assign hit[k] = (code == CODE_W'(k * LANE_W));
   end

   assign eff_code = (|hit) ? code : '0;
   assign shifted  = word >> eff_code;
   assign cost     = shifted[MASK_W-1:0];

endmodule

// File: rtl/cyc_cost_select.sv
module cyc_cost_select
   import cyc_budget_pkg::*;
#(
   parameter int LANE_W  = 8,
   parameter int NUM_VAR = 3,
   parameter int MASK_W  = 7,
   localparam int WORD_W = LANE_W * NUM_VAR,
   localparam int CODE_W = $clog2(WORD_W)
) (
   input  logic [CODE_W-1:0] variant_sel,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_kind,
   input  logic [WORD_W-1:0] cost_a,
   input  logic [WORD_W-1:0] cost_b,
   input  logic [LANE_W-1:0] cost_flat,
   input  logic [7:0]        modrm,
   input  logic              addr_lsb,
   output logic              charge_en,
   output logic [LANE_W-1:0] charge
);

   logic [MASK_W-1:0] lane_a, lane_b;
   logic [LANE_W-1:0] ext_a, ext_b;
   logic              reg_form;

   cyc_lane_pick #(.LANE_W(LANE_W), .NUM_VAR(NUM_VAR), .MASK_W(MASK_W)) u_pick_a (
      .word(cost_a), .code(variant_sel), .cost(lane_a)
   );

   cyc_lane_pick #(.LANE_W(LANE_W), .NUM_VAR(NUM_VAR), .MASK_W(MASK_W)) u_pick_b (
      .word(cost_b), .code(variant_sel), .cost(lane_b)
   );

   assign ext_a    = LANE_W'(lane_a);
   assign ext_b    = LANE_W'(lane_b);
   assign reg_form = (modrm >= REG_FORM_MIN);

   always_comb begin
      charge_en = cmd_valid;
      charge    = '0;
      unique case (cmd_kind)
         CK_FLAT:    charge = cost_flat;
         CK_VARIANT: charge = ext_a;
         CK_PARITY:  charge = addr_lsb ? ext_a : ext_b;
         CK_FORM:    charge = reg_form ? ext_a : ext_b;
         CK_MIXED:   charge = reg_form ? cost_flat : (addr_lsb ? ext_a : ext_b);
         default:    charge_en = 1'b0;
      endcase
   end

endmodule

// File: rtl/cyc_budget_counter.sv
module cyc_budget_counter #(
   parameter int CNT_W = 32,
   parameter int CHG_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic signed [CNT_W-1:0] load_value,
   input  logic                    charge_en,
   input  logic [CHG_W-1:0]        charge,
   output logic signed [CNT_W-1:0] budget,
   output logic                    exhausted
);

   logic signed [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (load)      cnt_q <= load_value;
      else if (charge_en) cnt_q <= cnt_q - signed'(CNT_W'(charge));
   end

   assign budget    = cnt_q;
   assign exhausted = (cnt_q <= 0);

endmodule

// File: rtl/cyc_budget_meter.sv
module cyc_budget_meter #(
   parameter int LANE_W  = 8,
   parameter int NUM_VAR = 3,
   parameter int MASK_W  = 7,
   parameter int CNT_W   = 32,
   localparam int WORD_W = LANE_W * NUM_VAR,
   localparam int CODE_W = $clog2(WORD_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CODE_W-1:0]       variant_sel,
   input  logic                    cmd_valid,
   input  logic [2:0]              cmd_kind,
   input  logic [WORD_W-1:0]       cost_a,
   input  logic [WORD_W-1:0]       cost_b,
   input  logic [LANE_W-1:0]       cost_flat,
   input  logic [7:0]              modrm,
   input  logic                    addr_lsb,
   input  logic                    load,
   input  logic signed [CNT_W-1:0] load_value,
   output logic signed [CNT_W-1:0] budget,
   output logic                    exhausted
);

   if (MASK_W > LANE_W) begin : g_bad_mask
      $error("MASK_W must not exceed LANE_W");
   end
   if (CNT_W <= LANE_W) begin : g_bad_cnt
      $error("CNT_W must exceed LANE_W");
   end
   if (NUM_VAR < 1) begin : g_bad_var
      $error("NUM_VAR must be at least 1");
   end

   logic              charge_en;
   logic [LANE_W-1:0] charge;

   cyc_cost_select #(.LANE_W(LANE_W), .NUM_VAR(NUM_VAR), .MASK_W(MASK_W)) u_select (
      .variant_sel(variant_sel),
      .cmd_valid  (cmd_valid),
      .cmd_kind   (cmd_kind),
      .cost_a     (cost_a),
      .cost_b     (cost_b),
      .cost_flat  (cost_flat),
      .modrm      (modrm),
      .addr_lsb   (addr_lsb),
      .charge_en  (charge_en),
      .charge     (charge)
   );

   cyc_budget_counter #(.CNT_W(CNT_W), .CHG_W(LANE_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_value(load_value),
      .charge_en (charge_en),
      .charge    (charge),
      .budget    (budget),
      .exhausted (exhausted)
   );

endmodule

// File: rtl/cyc_budget_checker.sv
module cyc_budget_checker #(
   parameter int LANE_W = 8,
   parameter int MASK_W = 7,
   parameter int CNT_W  = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cmd_valid,
   input logic [2:0]              cmd_kind,
   input logic [LANE_W-1:0]       cost_flat,
   input logic [7:0]              modrm,
   input logic                    load,
   input logic signed [CNT_W-1:0] load_value,
   input logic signed [CNT_W-1:0] budget,
   input logic                    exhausted
);

   localparam logic signed [CNT_W-1:0] LANE_MAX = CNT_W'((1 << MASK_W) - 1);

   assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> budget == $past(load_value));

   assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !cmd_valid) |=> $stable(budget));

   assert_flat_charge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cmd_valid && cmd_kind == 3'd0)
      |=> ($past(budget) - budget) == signed'(CNT_W'($past(cost_flat))));

   assert_mixed_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cmd_valid && cmd_kind == 3'd4 && modrm >= 8'hC0)
      |=> ($past(budget) - budget) == signed'(CNT_W'($past(cost_flat))));

   assert_lane_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cmd_valid && cmd_kind inside {3'd1, 3'd2, 3'd3})
      |=> (($past(budget) - budget) >= 0) && (($past(budget) - budget) <= LANE_MAX));

   assert_unused_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cmd_valid && cmd_kind >= 3'd5) |=> $stable(budget));

   assert_exhaust_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> exhausted == ($past(load_value) <= 0));

endmodule

bind cyc_budget_meter cyc_budget_checker #(
   .LANE_W(LANE_W), .MASK_W(MASK_W), .CNT_W(CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_kind  (cmd_kind),
   .cost_flat (cost_flat),
   .modrm     (modrm),
   .load      (load),
   .load_value(load_value),
   .budget    (budget),
   .exhausted (exhausted)
);

// File: tb/cyc_budget_meter_bench.sv
module cyc_budget_meter_bench;

   localparam int PERIOD = 10;

   typedef struct {
      int    exp_budget;
      string tag;
   } sb_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  variant_sel = '0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_kind = '0;
   logic [23:0] cost_a = '0;
   logic [23:0] cost_b = '0;
   logic [7:0]  cost_flat = '0;
   logic [7:0]  modrm = '0;
   logic        addr_lsb = 1'b0;
   logic        load = 1'b0;
   logic signed [31:0] load_value = '0;
   logic signed [31:0] budget;
   logic        exhausted;

   int n_checks = 0;
   int n_fail   = 0;
   int model    = 0;
   sb_item_t sb_q[$];

   always #(PERIOD/2) clk = ~clk;

   cyc_budget_meter u_cyc_budget_meter (
      .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel), .cmd_valid(cmd_valid),
      .cmd_kind(cmd_kind), .cost_a(cost_a), .cost_b(cost_b), .cost_flat(cost_flat),
      .modrm(modrm), .addr_lsb(addr_lsb), .load(load), .load_value(load_value),
      .budget(budget), .exhausted(exhausted)
   );

   function automatic int lane(input logic [23:0] w, input int code);
      int c;
      c = (code == 0 || code == 8 || code == 16) ? code : 0;
      return int'((w >> c) & 24'h7F);
   endfunction

   function automatic int cost_of(input int kind, input int code, input logic [23:0] a,
                                  input logic [23:0] b, input int flat, input int mr,
                                  input logic odd);
      case (kind)
         0: return flat;
         1: return lane(a, code);
         2: return odd ? lane(a, code) : lane(b, code);
         3: return (mr >= 'hC0) ? lane(a, code) : lane(b, code);
         4: return (mr >= 'hC0) ? flat : (odd ? lane(a, code) : lane(b, code));
         default: return 0;
      endcase
   endfunction

   task automatic drive(input logic v, input int kind, input int code, input logic [23:0] a,
                        input logic [23:0] b, input int flat, input int mr, input logic odd,
                        input logic ld, input int ldv, input string tag);
      sb_item_t it;
      @(negedge clk);
      cmd_valid   = v;
      cmd_kind    = 3'(kind);
      variant_sel = 5'(code);
      cost_a      = a;
      cost_b      = b;
      cost_flat   = 8'(flat);
      modrm       = 8'(mr);
      addr_lsb    = odd;
      load        = ld;
      load_value  = ldv;
      if (ld)     model = ldv;
      else if (v) model = model - cost_of(kind, code, a, b, flat, mr, odd);
      it.exp_budget = model;
      it.tag        = tag;
      sb_q.push_back(it);
   endtask

   task automatic idle(input string tag);
      drive(1'b0, 0, 0, '0, '0, 0, 0, 1'b0, 1'b0, 0, tag);
   endtask

   // Monitor: compares each result a quarter period after the edge that made it
   initial begin
      forever begin
         @(posedge clk);
         #(PERIOD/4);
         if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (budget !== it.exp_budget) begin
               n_fail++;
               $display("FAIL %s budget actual=%0d expected=%0d", it.tag, budget, it.exp_budget);
            end
            n_checks++;
            if (exhausted !== (it.exp_budget <= 0)) begin
               n_fail++;
               $display("FAIL R10 (%s) exhausted actual=%0b expected=%0b", it.tag,
                        exhausted, (it.exp_budget <= 0));
            end
         end
      end
   end

   initial begin
      #(PERIOD * 100000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   localparam logic [23:0] WA = 24'hC5_93_0A;
   localparam logic [23:0] WB = 24'h21_7F_03;

   initial begin
      repeat (2) @(negedge clk);
      n_checks++; // R1 reset state
      if (budget !== 0 || exhausted !== 1'b1) begin
         n_fail++;
         $display("FAIL R1 reset actual=%0d/%0b expected=0/1", budget, exhausted);
      end
      rst_n = 1'b1;

      drive(1'b0, 0, 0, '0, '0, 0, 0, 1'b0, 1'b1, 1000, "R2");
      drive(1'b1, 0, 0, '0, '0, 9, 0, 1'b0, 1'b0, 0, "R5");
      drive(1'b1, 0, 16, '0, '0, 200, 0, 1'b0, 1'b0, 0, "R5");
      drive(1'b1, 1, 0, WA, WB, 0, 0, 1'b0, 1'b0, 0, "R9");
      drive(1'b1, 1, 8, WA, WB, 0, 0, 1'b0, 1'b0, 0, "R3");
      drive(1'b1, 1, 16, WA, WB, 0, 0, 1'b0, 1'b0, 0, "R3");
      drive(1'b1, 1, 5, WA, WB, 0, 0, 1'b0, 1'b0, 0, "R4");
      drive(1'b1, 1, 24, WA, WB, 0, 0, 1'b0, 1'b0, 0, "R4");
      drive(1'b1, 2, 8, WA, WB, 0, 0, 1'b1, 1'b0, 0, "R6");
      drive(1'b1, 2, 8, WA, WB, 0, 0, 1'b0, 1'b0, 0, "R6");
      drive(1'b1, 3, 16, WA, WB, 0, 'hC0, 1'b0, 1'b0, 0, "R7");
      drive(1'b1, 3, 16, WA, WB, 0, 'hBF, 1'b0, 1'b0, 0, "R7");
      drive(1'b1, 4, 0, WA, WB, 33, 'hFF, 1'b1, 1'b0, 0, "R8");
      drive(1'b1, 4, 8, WA, WB, 33, 'h40, 1'b1, 1'b0, 0, "R8");
      drive(1'b1, 4, 8, WA, WB, 33, 'h40, 1'b0, 1'b0, 0, "R8");
      drive(1'b1, 5, 0, WA, WB, 50, 0, 1'b1, 1'b0, 0, "R9");
      drive(1'b1, 6, 8, WA, WB, 50, 0, 1'b1, 1'b0, 0, "R9");
      drive(1'b1, 7, 16, WA, WB, 50, 'hC0, 1'b1, 1'b0, 0, "R9");
      idle("R11");
      idle("R11");
      drive(1'b1, 0, 0, '0, '0, 77, 0, 1'b0, 1'b1, 20, "R2");
      drive(1'b1, 0, 0, '0, '0, 20, 0, 1'b0, 1'b0, 0, "R10");
      drive(1'b1, 0, 0, '0, '0, 1, 0, 1'b0, 1'b0, 0, "R10");
      drive(1'b0, 0, 0, '0, '0, 0, 0, 1'b0, 1'b1, 1, "R10");
      drive(1'b0, 0, 0, '0, '0, 0, 0, 1'b0, 1'b1, -5, "R10");
      idle("R11");
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule